// File: doc/BRIEF.md
# Machine-Level CSR File

This block holds the machine-level control and status registers of a small hart whose register width is 32 or 64 bits, chosen by a parameter. The execute stage presents one CSR instruction at a time: its kind, its 12-bit CSR address, its destination and source register indices, and the source register value. In the same cycle the block returns the old CSR value for the register file, or flags an illegal access. Any update is committed at the next clock edge.

The register and immediate forms of read-write, read-set and read-clear are supported, including the rules under which the read or the write is skipped. The interrupt enable and pending registers are the only writable entries, and they keep only a fixed set of bits. A 64-bit counter advances once for every retired instruction and is exposed both as the cycle counter and as the retired-instruction counter. The block also answers the identification registers, and it returns zero for the unused counters and event selectors.

Top module: `mcsr_file`

## Requirements
- R1: After reset the interrupt enable and pending registers and the 64-bit counter read zero. The hart ID register holds the value that `hart_id_i` had while `rst_n` was low, and later changes on `hart_id_i` do not reach it.
- R2: Address 0x301 reads a constant: bit 8 set, the two most significant bits equal to 1 for 32-bit width or 2 for 64-bit width, and every other bit zero.
- R3: Writes to 0x304 (interrupt enable) and 0x344 (interrupt pending) keep only the bits set in 0x0BBB, so every other bit always reads back as zero.
- R4: Addresses 0x302, 0x303, 0x305, 0x340, 0x341, 0x342 and 0x343 read zero, and writes to them are discarded.
- R5: The 64-bit counter increases by one on each clock edge where `retire_i` is high and is unchanged otherwise. At 64-bit width 0xB00 reads all of it. At 32-bit width 0xB00 reads the low half and 0xB80 the high half.
- R6: Addresses 0xB02 and 0xB82 return exactly what 0xB00 and 0xB80 return.
- R7: 0xB03 to 0xB1F and 0xB23 to 0xB3F read zero. 0xB83 to 0xB9F read zero at 32-bit width and are unmapped at 64-bit width, as are 0xB80 and 0xB82.
- R8: 0xF11 and 0xF12 read zero. 0xF13 reads {major, minor, patch} with patch in bits 7:0, minor in bits 15:8, major in bits 23:16, and zero above. 0xF14 reads the hart ID.
- R9: A read of any other address raises `illegal_o`, leaves `rd_we_o` low and `rd_val_o` zero, and commits no write.
- R10: `op_kind_i[1:0]` selects 01 read-write, 10 read-set or 11 read-clear, and 00 is a no-op that reads nothing and writes nothing. A read-write with `rd_idx_i` equal to 0 performs no read: `rd_we_o` and `illegal_o` stay low, and the write still happens.
- R11: Read-set writes old OR operand. Read-clear writes old AND NOT operand. Both always read, and they write nothing when `rs1_idx_i` is 0.
- R12: When `op_kind_i[2]` is 1 the operand is `rs1_idx_i` zero-extended instead of `rs1_val_i`.
- R13: An instruction that reads and writes the same register returns the old value in that cycle, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also captures the hart ID |
| hart_id_i | input | XLEN | Hart ID captured while in reset |
| retire_i | input | 1 | One instruction retires this cycle |
| op_valid_i | input | 1 | A CSR instruction is presented |
| op_kind_i | input | 3 | Bit 2 selects the immediate form; bits 1:0 select write, set or clear |
| csr_addr_i | input | 12 | CSR address |
| rd_idx_i | input | 5 | Destination register index |
| rs1_idx_i | input | 5 | Source register index or 5-bit immediate |
| rs1_val_i | input | XLEN | Source register value |
| rd_val_o | output | XLEN | Old CSR value for write-back |
| rd_we_o | output | 1 | `rd_val_o` is to be written back |
| illegal_o | output | 1 | Unmapped address read |

## Verification
The assertions assume that the `op_*` inputs are stable across the whole cycle in which they are sampled, and that `retire_i` is meaningful in every cycle after reset whether or not a CSR instruction is present. The bench changes all inputs only at the falling edge and holds them through the rising edge. During the address sweep it keeps `retire_i` low, so that the counter, and with it the expected values at the counter addresses, stays fixed. Where the counter is exercised, the bench predicts the value from the number of retiring cycles it has driven since reset.

// File: rtl/mcsr_file.sv
module mcsr_file #(
  parameter int XLEN      = 32,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0,
  parameter int VER_PATCH = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] hart_id_i,
  input  logic            retire_i,
  input  logic            op_valid_i,
  input  logic [2:0]      op_kind_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [4:0]      rd_idx_i,
  input  logic [4:0]      rs1_idx_i,
  input  logic [XLEN-1:0] rs1_val_i,
  output logic [XLEN-1:0] rd_val_o,
  output logic            rd_we_o,
  output logic            illegal_o
);
  localparam bit              IS64  = (XLEN == 64);
  localparam logic [1:0]      MXL   = IS64 ? 2'd2 : 2'd1;
  localparam logic [XLEN-1:0] WMASK = XLEN'(16'h0BBB);
  localparam logic [XLEN-1:0] MISA  = {MXL, {(XLEN-2){1'b0}}} | XLEN'(32'h100);
  localparam logic [23:0]     VER   = {8'(VER_MAJOR), 8'(VER_MINOR), 8'(VER_PATCH)};
  localparam logic [XLEN-1:0] IMPID = XLEN'(VER);

  logic [XLEN-1:0] ie_q, ip_q, hart_q, old_val, operand, new_val;
  logic [63:0]     cnt_q;
  logic            hit;

  always_comb begin
    hit     = 1'b1;
    old_val = '0;
    case (csr_addr_i) inside
      12'h301:                     old_val = MISA;
      12'h304:                     old_val = ie_q;
      12'h344:                     old_val = ip_q;
      12'h302, 12'h303, 12'h305,
      [12'h340:12'h343]:           old_val = '0;
      12'hB00, 12'hB02:            old_val = IS64 ? XLEN'(cnt_q) : XLEN'(cnt_q[31:0]);
      12'hB80, 12'hB82: begin
        hit     = !IS64;
        old_val = IS64 ? '0 : XLEN'(cnt_q[63:32]);
      end
      [12'hB03:12'hB1F],
      [12'hB23:12'hB3F]:           old_val = '0;
      [12'hB83:12'hB9F]:           hit = !IS64;
      12'hF11, 12'hF12:            old_val = '0;
      12'hF13:                     old_val = IMPID;
      12'hF14:                     old_val = hart_q;
      default:                     hit = 1'b0;
    endcase
  end

  wire is_rw  = (op_kind_i[1:0] == 2'b01);
  wire is_set = (op_kind_i[1:0] == 2'b10);
  wire is_clr = (op_kind_i[1:0] == 2'b11);
  wire rd_req = op_valid_i & (is_rw ? (rd_idx_i != 5'd0) : (is_set | is_clr));
  wire wr_req = op_valid_i & (is_rw | ((is_set | is_clr) & (rs1_idx_i != 5'd0)));

  assign operand   = op_kind_i[2] ? XLEN'(rs1_idx_i) : rs1_val_i;
  assign new_val   = is_rw ? operand : (is_set ? (old_val | operand) : (old_val & ~operand));
  assign illegal_o = rd_req & ~hit;
  assign rd_we_o   = rd_req & hit;
  assign rd_val_o  = rd_we_o ? old_val : '0;

  wire commit = wr_req & ~illegal_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      ip_q   <= '0;
      cnt_q  <= '0;
      hart_q <= hart_id_i;
    end else begin
      if (retire_i) cnt_q <= cnt_q + 64'd1;
      if (commit && csr_addr_i == 12'h304) ie_q <= new_val & WMASK;
      if (commit && csr_addr_i == 12'h344) ip_q <= new_val & WMASK;
    end
  end

  a_r3_reserved_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we_o && (csr_addr_i == 12'h304 || csr_addr_i == 12'h344)) |-> ((rd_val_o & ~WMASK) == '0));

  a_r5_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> $stable(cnt_q));

  a_r9_illegal_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> ($stable(ie_q) && $stable(ip_q)));

  a_r10_rw_x0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && is_rw && rd_idx_i == 5'd0) |-> (!illegal_o && !rd_we_o));

  a_r11_zero_source_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (is_set || is_clr) && rs1_idx_i == 5'd0) |=> ($stable(ie_q) && $stable(ip_q)));

  a_r1_hart_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we_o && csr_addr_i == 12'hF14) |=> (csr_addr_i != 12'hF14 || !rd_we_o || $stable(rd_val_o)));
endmodule

// File: tb/mcsr_file_test.sv
`timescale 1ns/1ps
module mcsr_file_test;
  localparam int XLEN = 32;
  localparam logic [31:0] MASK = 32'h0000_0BBB;
  localparam logic [31:0] HART = 32'h0000_0005;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] hart_id_i = HART;
  logic retire_i = 1'b0;
  logic op_valid_i = 1'b0;
  logic [2:0] op_kind_i = '0;
  logic [11:0] csr_addr_i = '0;
  logic [4:0] rd_idx_i = '0, rs1_idx_i = '0;
  logic [31:0] rs1_val_i = '0;
  logic [31:0] rd_val_o;
  logic rd_we_o, illegal_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] ie_m = '0, ip_m = '0;
  logic [63:0] cnt_m = '0;

  always #4 clk = ~clk;

  mcsr_file #(.XLEN(XLEN), .VER_MAJOR(1), .VER_MINOR(2), .VER_PATCH(3)) uut (
    .clk(clk), .rst_n(rst_n), .hart_id_i(hart_id_i), .retire_i(retire_i),
    .op_valid_i(op_valid_i), .op_kind_i(op_kind_i), .csr_addr_i(csr_addr_i),
    .rd_idx_i(rd_idx_i), .rs1_idx_i(rs1_idx_i), .rs1_val_i(rs1_val_i),
    .rd_val_o(rd_val_o), .rd_we_o(rd_we_o), .illegal_o(illegal_o));

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_read(input logic [11:0] a, output bit ok, output logic [31:0] v);
    ok = 1'b1; v = '0;
    if (a == 12'h301) v = 32'h4000_0100;
    else if (a == 12'h304) v = ie_m;
    else if (a == 12'h344) v = ip_m;
    else if (a == 12'h302 || a == 12'h303 || a == 12'h305 || (a >= 12'h340 && a <= 12'h343)) v = '0;
    else if (a == 12'hB00 || a == 12'hB02) v = cnt_m[31:0];
    else if (a == 12'hB80 || a == 12'hB82) v = cnt_m[63:32];
    else if ((a >= 12'hB03 && a <= 12'hB1F) || (a >= 12'hB23 && a <= 12'hB3F) ||
             (a >= 12'hB83 && a <= 12'hB9F)) v = '0;
    else if (a == 12'hF11 || a == 12'hF12) v = '0;
    else if (a == 12'hF13) v = 32'h0001_0203;
    else if (a == 12'hF14) v = HART;
    else ok = 1'b0;
  endtask

  function automatic string tag_of(input logic [11:0] a);
    if (a == 12'h301) return "R2";
    if (a == 12'h304 || a == 12'h344) return "R3";
    if (a == 12'h302 || a == 12'h303 || a == 12'h305 || (a >= 12'h340 && a <= 12'h343)) return "R4";
    if (a == 12'hB00 || a == 12'hB80) return "R5";
    if (a == 12'hB02 || a == 12'hB82) return "R6";
    if (a[11:8] == 4'hB) return "R7";
    if (a[11:8] == 4'hF && a[7:0] >= 8'h11 && a[7:0] <= 8'h14) return "R8";
    return "R9";
  endfunction

  task automatic op(input logic [2:0] kind, input logic [11:0] a, input logic [4:0] rd,
                    input logic [4:0] rs1, input logic [31:0] val, input bit ret, input string tag);
    bit ok, rrq, wrq, eill, ewe;
    logic [31:0] ev, eval, opnd, nv;
    @(negedge clk);
    op_valid_i = 1'b1; op_kind_i = kind; csr_addr_i = a;
    rd_idx_i = rd; rs1_idx_i = rs1; rs1_val_i = val; retire_i = ret;
    #2;
    model_read(a, ok, ev);
    rrq  = (kind[1:0] == 2'b01) ? (rd != 0) : (kind[1:0] != 2'b00);
    wrq  = (kind[1:0] == 2'b01) || (kind[1:0] != 2'b00 && rs1 != 0);
    eill = rrq && !ok;
    ewe  = rrq && ok;
    eval = ewe ? ev : '0;
    chk(rd_we_o == ewe && illegal_o == eill && rd_val_o == eval, tag,
        {rd_we_o, illegal_o, rd_val_o}, {ewe, eill, eval});
    opnd = kind[2] ? {27'd0, rs1} : val;
    nv = (kind[1:0] == 2'b01) ? opnd : (kind[1:0] == 2'b10) ? (ev | opnd) : (ev & ~opnd);
    @(posedge clk);
    if (wrq && !eill && a == 12'h304) ie_m = nv & MASK;
    if (wrq && !eill && a == 12'h344) ip_m = nv & MASK;
    if (ret) cnt_m = cnt_m + 64'd1;
    #1;
    op_valid_i = 1'b0; retire_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    hart_id_i = 32'h0000_0009;
    // R1: reset state and hart capture
    op(3'b010, 12'h304, 5'd1, 5'd0, 32'hFFFF_FFFF, 1'b0, "R1");
    op(3'b010, 12'h344, 5'd1, 5'd0, 32'hFFFF_FFFF, 1'b0, "R1");
    op(3'b010, 12'hB00, 5'd1, 5'd0, 32'h0, 1'b0, "R1");
    op(3'b010, 12'hF14, 5'd1, 5'd0, 32'h0, 1'b0, "R1");
    // full address sweep, read-only set form
    for (int a = 0; a < 4096; a++) op(3'b010, 12'(a), 5'd3, 5'd0, 32'hA5A5_A5A5, 1'b0, tag_of(12'(a)));
    // R3 and R13: masked writes, old value returned
    op(3'b001, 12'h304, 5'd2, 5'd7, 32'hFFFF_FFFF, 1'b0, "R13");
    op(3'b001, 12'h304, 5'd2, 5'd7, 32'h1234_5678, 1'b0, "R3");
    op(3'b001, 12'h344, 5'd2, 5'd7, 32'hFFFF_F444, 1'b0, "R3");
    op(3'b010, 12'h344, 5'd2, 5'd0, 32'h0, 1'b0, "R3");
    // R11: set and clear, zero source index suppresses write
    op(3'b010, 12'h304, 5'd4, 5'd6, 32'h0000_0801, 1'b0, "R11");
    op(3'b011, 12'h304, 5'd4, 5'd6, 32'h0000_0230, 1'b0, "R11");
    op(3'b011, 12'h304, 5'd4, 5'd0, 32'hFFFF_FFFF, 1'b0, "R11");
    op(3'b010, 12'h344, 5'd4, 5'd0, 32'hFFFF_FFFF, 1'b0, "R11");
    op(3'b010, 12'h304, 5'd4, 5'd0, 32'h0, 1'b0, "R11");
    // R12: immediate forms
    op(3'b101, 12'h344, 5'd5, 5'h15, 32'hFFFF_FFFF, 1'b0, "R12");
    op(3'b110, 12'h344, 5'd5, 5'h1F, 32'h0, 1'b0, "R12");
    op(3'b111, 12'h344, 5'd5, 5'h03, 32'hFFFF_FFFF, 1'b0, "R12");
    op(3'b111, 12'h344, 5'd5, 5'h00, 32'hFFFF_FFFF, 1'b0, "R12");
    op(3'b010, 12'h344, 5'd5, 5'h00, 32'h0, 1'b0, "R12");
    // R10: x0 destination and no-op kinds
    op(3'b001, 12'h7C0, 5'd0, 5'd1, 32'hFFFF_FFFF, 1'b0, "R10");
    op(3'b001, 12'h304, 5'd0, 5'd1, 32'h0000_00FF, 1'b0, "R10");
    op(3'b000, 12'h304, 5'd1, 5'd1, 32'h0000_0000, 1'b0, "R10");
    op(3'b100, 12'h344, 5'd1, 5'd9, 32'h0000_0000, 1'b0, "R10");
    op(3'b010, 12'h304, 5'd1, 5'd0, 32'h0, 1'b0, "R10");
    op(3'b010, 12'h344, 5'd1, 5'd0, 32'h0, 1'b0, "R10");
    // R4: trap registers discard writes; R9: illegal writes leave state
    op(3'b001, 12'h305, 5'd1, 5'd2, 32'hFFFF_FFFF, 1'b0, "R4");
    op(3'b010, 12'h341, 5'd1, 5'd2, 32'hFFFF_FFFF, 1'b0, "R4");
    op(3'b010, 12'h305, 5'd1, 5'd0, 32'h0, 1'b0, "R4");
    op(3'b011, 12'h300, 5'd1, 5'd2, 32'hFFFF_FFFF, 1'b0, "R9");
    op(3'b010, 12'h306, 5'd1, 5'd2, 32'hFFFF_FFFF, 1'b0, "R9");
    // R5 and R6: counter advances only on retiring cycles
    for (int i = 0; i < 37; i++) op(3'b000, 12'h000, 5'd0, 5'd0, 32'h0, (i % 3) != 1, "R5");
    op(3'b010, 12'hB00, 5'd1, 5'd0, 32'h0, 1'b1, "R5");
    op(3'b010, 12'hB00, 5'd1, 5'd0, 32'h0, 1'b0, "R5");
    op(3'b010, 12'hB80, 5'd1, 5'd0, 32'h0, 1'b0, "R5");
    op(3'b010, 12'hB02, 5'd1, 5'd0, 32'h0, 1'b0, "R6");
    op(3'b010, 12'hB82, 5'd1, 5'd0, 32'h0, 1'b0, "R6");
    for (int a = 12'hB00; a < 12'hBA0; a++) op(3'b010, 12'(a), 5'd3, 5'd0, 32'h0, 1'b0, tag_of(12'(a)));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule